// File: doc/BRIEF.md
# Microcode Sequencer with Jump Logic

This block is the control half of a small microprogrammed processor. A micro-PC register names one word of a control store. Each word supplies the datapath strobes for the current cycle. It also gives a three-bit jump type and an absolute micro-address, and together they decide which word comes next. The control store is a combinational case table indexed by the micro-PC. The micro-PC itself updates on the rising clock edge.

The jump logic picks the next micro-PC from four sources: the current address plus one, the current address held, the absolute target from the word, or the start address of an instruction group. That group is found by decoding the macro-instruction opcode. The sequencer watches three inputs: a memory busy flag, which stalls the memory-wait steps, a branch-compare flag, which steers the conditional steps, and the opcode. The microprogram covers instruction fetch, register ALU, immediate ALU, load, store, branch-if-equal, branch-if-not-equal and jump. Any unknown opcode parks the machine in a trap word.

Top module: `useq_core`

## Requirements
- R1: While `rst` is high at a rising edge, the micro-PC becomes 0, the first fetch step.
- R2: Jump type NEXT (code 0) loads micro-PC + 1.
- R3: Jump type SPIN (code 1) keeps the micro-PC unchanged while `mem_busy` is 1, and loads micro-PC + 1 when it is 0.
- R4: Jump type FETCH (code 2) loads the word's absolute target. Every instruction routine ends by jumping to address 0.
- R5: Jump type DISPATCH (code 3) loads the group start for `opcode`: 0x33 goes to 4, 0x13 to 7, 0x03 to 10, 0x23 to 15, 0x63 to 20, 0x6F to 26 and 0x67 to 29.
- R6: Jump type FTRUE (code 4) loads the target when `br_cmp` is 1 and micro-PC + 1 otherwise. FFALSE (code 5) loads the target when `br_cmp` is 0 and micro-PC + 1 otherwise.
- R7: Fetch runs steps 0, 1, 2 and 3 with jump types NEXT, SPIN, NEXT and DISPATCH. The strobe byte `ctrl[16:9]` is 0x06 at step 0, 0xA0 at step 1, 0x12 at step 2 and 0x01 at step 3.
- R8: A load runs steps 10 to 14, waiting at step 13 (strobes 0x81) while memory is busy. A store runs steps 15 to 19, waiting at step 18 (strobes 0xC2). Steps 14 and 19 carry strobes 0x00.
- R9: Branch-if-equal runs steps 20 to 22. With `br_cmp` at 0 it returns to 0 after step 22; with `br_cmp` at 1 it continues through 23, 24 and 25 and then returns to 0. Branch-if-not-equal runs steps 29 to 31. With `br_cmp` at 1 it returns to 0; otherwise it goes through 32 into the shared taken path at 23. Step 22 carries strobes 0x12 and step 25 carries 0x01.
- R10: Any opcode not listed in R5 dispatches to the trap address (all ones, 63). The sequencer stays there, with strobes 0x00, until reset.
- R11: `ctrl` bit layout, from bit 16 down: memory enable, memory write, IR load, A load, B load, address load, register bus enable, register write, register select [8:6], ALU bus enable [5], ALU function [4:3], immediate bus enable [2], immediate select [1:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | OPC_W | Opcode of the instruction held in IR |
| mem_busy | input | 1 | Memory access still in progress |
| br_cmp | input | 1 | Branch comparison result from the datapath |
| ctrl | output | 17 | Datapath control strobes for the current step |
| upc | output | UPC_W | Current micro-PC |

## Verification
The bench uses the default parameters: a 6-bit micro-PC and a 7-bit opcode. With these the trap word lands on address 63, the top of the address space, so a stuck trap and an all-ones wraparound both show up. The stimulus sends a mix of instruction types. Fetch and memory waits last from zero to three busy cycles, both branch flavours run with the compare flag in each state, and an unknown opcode comes last. This sequence takes every jump type down both of its arms.

// File: rtl/useq_pkg.sv
package useq_pkg;

  localparam int CTRL_W = 17;

  typedef enum logic [2:0] {
    JT_NEXT   = 3'd0,
    JT_SPIN   = 3'd1,
    JT_FETCH  = 3'd2,
    JT_DISP   = 3'd3,
    JT_FTRUE  = 3'd4,
    JT_FFALSE = 3'd5
  } jump_e;

  typedef struct packed {
    logic       mem_en;
    logic       mem_wr;
    logic       ld_ir;
    logic       ld_a;
    logic       ld_b;
    logic       ld_ma;
    logic       reg_oe;
    logic       reg_we;
    logic [2:0] reg_sel;
    logic       alu_oe;
    logic [1:0] alu_fn;
    logic       imm_oe;
    logic [1:0] imm_sel;
  } ctrl_t;

  // register select codes
  localparam logic [2:0] RS_PC   = 3'd0;
  localparam logic [2:0] RS_SRC1 = 3'd1;
  localparam logic [2:0] RS_SRC2 = 3'd2;
  localparam logic [2:0] RS_DST  = 3'd3;
  localparam logic [2:0] RS_LINK = 3'd4;

  // ALU function codes
  localparam logic [1:0] AF_ADD  = 2'd0;
  localparam logic [1:0] AF_INC4 = 2'd1;
  localparam logic [1:0] AF_DEC4 = 2'd2;
  localparam logic [1:0] AF_FUNC = 2'd3;

  // immediate select codes
  localparam logic [1:0] IS_ITYPE = 2'd0;
  localparam logic [1:0] IS_BRSH  = 2'd1;
  localparam logic [1:0] IS_JOFF  = 2'd2;

  // routine entry points
  localparam int UA_FETCH = 0;
  localparam int UA_ALU   = 4;
  localparam int UA_ALUI  = 7;
  localparam int UA_LOAD  = 10;
  localparam int UA_STORE = 15;
  localparam int UA_BEQ   = 20;
  localparam int UA_TAKEN = 23;
  localparam int UA_JMP   = 26;
  localparam int UA_BNE   = 29;

  // opcode values
  localparam int OP_ALU   = 'h33;
  localparam int OP_ALUI  = 'h13;
  localparam int OP_LOAD  = 'h03;
  localparam int OP_STORE = 'h23;
  localparam int OP_BEQ   = 'h63;
  localparam int OP_BNE   = 'h67;
  localparam int OP_JMP   = 'h6F;

endpackage

// File: rtl/useq_dispatch.sv
module useq_dispatch
  import useq_pkg::*;
#(
  parameter int OPC_W = 7,
  parameter int UPC_W = 6
) (
  input  logic [OPC_W-1:0] opcode,
  output logic [UPC_W-1:0] grp_start
);
  localparam logic [UPC_W-1:0] TRAP = {UPC_W{1'b1}};

  always_comb begin
    unique case (opcode)
      OPC_W'(OP_ALU):   grp_start = UPC_W'(UA_ALU);
      OPC_W'(OP_ALUI):  grp_start = UPC_W'(UA_ALUI);
      OPC_W'(OP_LOAD):  grp_start = UPC_W'(UA_LOAD);
      OPC_W'(OP_STORE): grp_start = UPC_W'(UA_STORE);
      OPC_W'(OP_BEQ):   grp_start = UPC_W'(UA_BEQ);
      OPC_W'(OP_BNE):   grp_start = UPC_W'(UA_BNE);
      OPC_W'(OP_JMP):   grp_start = UPC_W'(UA_JMP);
      default:          grp_start = TRAP;
    endcase
  end
endmodule

// File: rtl/useq_store.sv
module useq_store
  import useq_pkg::*;
#(
  parameter int UPC_W = 6
) (
  input  logic [UPC_W-1:0] upc,
  output ctrl_t            word_ctrl,
  output jump_e            word_jt,
  output logic [UPC_W-1:0] word_tgt
);
  localparam logic [UPC_W-1:0] TRAP = {UPC_W{1'b1}};

  always_comb begin
    word_ctrl = '0;
    word_jt   = JT_NEXT;
    word_tgt  = UPC_W'(UA_FETCH);
    case (upc)
      // fetch
      UPC_W'(0):  begin word_ctrl.reg_oe = 1'b1; word_ctrl.reg_sel = RS_PC; word_ctrl.ld_ma = 1'b1; end
      UPC_W'(1):  begin word_ctrl.mem_en = 1'b1; word_ctrl.ld_ir = 1'b1; word_jt = JT_SPIN; end
      UPC_W'(2):  begin word_ctrl.reg_oe = 1'b1; word_ctrl.reg_sel = RS_PC; word_ctrl.ld_a = 1'b1; end
      UPC_W'(3):  begin word_ctrl.alu_oe = 1'b1; word_ctrl.alu_fn = AF_INC4; word_ctrl.reg_we = 1'b1;
                        word_ctrl.reg_sel = RS_PC; word_jt = JT_DISP; end
      // register ALU
      UPC_W'(4):  begin word_ctrl.reg_oe = 1'b1; word_ctrl.reg_sel = RS_SRC1; word_ctrl.ld_a = 1'b1; end
      UPC_W'(5):  begin word_ctrl.reg_oe = 1'b1; word_ctrl.reg_sel = RS_SRC2; word_ctrl.ld_b = 1'b1; end
      UPC_W'(6):  begin word_ctrl.alu_oe = 1'b1; word_ctrl.alu_fn = AF_FUNC; word_ctrl.reg_we = 1'b1;
                        word_ctrl.reg_sel = RS_DST; word_jt = JT_FETCH; end
      // immediate ALU
      UPC_W'(7):  begin word_ctrl.reg_oe = 1'b1; word_ctrl.reg_sel = RS_SRC1; word_ctrl.ld_a = 1'b1; end
      UPC_W'(8):  begin word_ctrl.imm_oe = 1'b1; word_ctrl.imm_sel = IS_ITYPE; word_ctrl.ld_b = 1'b1; end
      UPC_W'(9):  begin word_ctrl.alu_oe = 1'b1; word_ctrl.alu_fn = AF_FUNC; word_ctrl.reg_we = 1'b1;
                        word_ctrl.reg_sel = RS_DST; word_jt = JT_FETCH; end
      // load
      UPC_W'(10): begin word_ctrl.reg_oe = 1'b1; word_ctrl.reg_sel = RS_SRC1; word_ctrl.ld_a = 1'b1; end
      UPC_W'(11): begin word_ctrl.imm_oe = 1'b1; word_ctrl.imm_sel = IS_ITYPE; word_ctrl.ld_b = 1'b1; end
      UPC_W'(12): begin word_ctrl.alu_oe = 1'b1; word_ctrl.alu_fn = AF_ADD; word_ctrl.ld_ma = 1'b1; end
      UPC_W'(13): begin word_ctrl.mem_en = 1'b1; word_ctrl.reg_we = 1'b1; word_ctrl.reg_sel = RS_DST;
                        word_jt = JT_SPIN; end
      UPC_W'(14): word_jt = JT_FETCH;
      // store
      UPC_W'(15): begin word_ctrl.reg_oe = 1'b1; word_ctrl.reg_sel = RS_SRC1; word_ctrl.ld_a = 1'b1; end
      UPC_W'(16): begin word_ctrl.imm_oe = 1'b1; word_ctrl.imm_sel = IS_BRSH; word_ctrl.ld_b = 1'b1; end
      UPC_W'(17): begin word_ctrl.alu_oe = 1'b1; word_ctrl.alu_fn = AF_ADD; word_ctrl.ld_ma = 1'b1; end
      UPC_W'(18): begin word_ctrl.mem_en = 1'b1; word_ctrl.mem_wr = 1'b1; word_ctrl.reg_oe = 1'b1;
                        word_ctrl.reg_sel = RS_SRC2; word_jt = JT_SPIN; end
      UPC_W'(19): word_jt = JT_FETCH;
      // branch if equal
      UPC_W'(20): begin word_ctrl.reg_oe = 1'b1; word_ctrl.reg_sel = RS_SRC1; word_ctrl.ld_a = 1'b1; end
      UPC_W'(21): begin word_ctrl.reg_oe = 1'b1; word_ctrl.reg_sel = RS_SRC2; word_ctrl.ld_b = 1'b1; end
      UPC_W'(22): begin word_ctrl.reg_oe = 1'b1; word_ctrl.reg_sel = RS_PC; word_ctrl.ld_a = 1'b1;
                        word_jt = JT_FFALSE; end
      // shared taken path
      UPC_W'(23): begin word_ctrl.alu_oe = 1'b1; word_ctrl.alu_fn = AF_DEC4; word_ctrl.ld_a = 1'b1; end
      UPC_W'(24): begin word_ctrl.imm_oe = 1'b1; word_ctrl.imm_sel = IS_BRSH; word_ctrl.ld_b = 1'b1; end
      UPC_W'(25): begin word_ctrl.alu_oe = 1'b1; word_ctrl.alu_fn = AF_ADD; word_ctrl.reg_we = 1'b1;
                        word_ctrl.reg_sel = RS_PC; word_jt = JT_FETCH; end
      // jump
      UPC_W'(26): begin word_ctrl.reg_oe = 1'b1; word_ctrl.reg_sel = RS_PC; word_ctrl.ld_a = 1'b1; end
      UPC_W'(27): begin word_ctrl.imm_oe = 1'b1; word_ctrl.imm_sel = IS_JOFF; word_ctrl.ld_b = 1'b1; end
      UPC_W'(28): begin word_ctrl.alu_oe = 1'b1; word_ctrl.alu_fn = AF_ADD; word_ctrl.reg_we = 1'b1;
                        word_ctrl.reg_sel = RS_PC; word_jt = JT_FETCH; end
      // branch if not equal
      UPC_W'(29): begin word_ctrl.reg_oe = 1'b1; word_ctrl.reg_sel = RS_SRC1; word_ctrl.ld_a = 1'b1; end
      UPC_W'(30): begin word_ctrl.reg_oe = 1'b1; word_ctrl.reg_sel = RS_SRC2; word_ctrl.ld_b = 1'b1; end
      UPC_W'(31): begin word_ctrl.reg_oe = 1'b1; word_ctrl.reg_sel = RS_PC; word_ctrl.ld_a = 1'b1;
                        word_jt = JT_FTRUE; end
      UPC_W'(32): begin word_jt = JT_FETCH; word_tgt = UPC_W'(UA_TAKEN); end
      // trap for unknown opcodes
      TRAP:       begin word_jt = JT_FETCH; word_tgt = TRAP; end
      default:    begin word_jt = JT_FETCH; word_tgt = TRAP; end
    endcase
  end
endmodule

// File: rtl/useq_next.sv
module useq_next
  import useq_pkg::*;
#(
  parameter int UPC_W = 6
) (
  input  logic [UPC_W-1:0] upc,
  input  jump_e            jt,
  input  logic [UPC_W-1:0] tgt,
  input  logic [UPC_W-1:0] grp_start,
  input  logic             mem_busy,
  input  logic             br_cmp,
  output logic [UPC_W-1:0] upc_nxt
);
  logic [UPC_W-1:0] upc_inc;
  assign upc_inc = upc + UPC_W'(1);

  always_comb begin
    unique case (jt)
      JT_NEXT:   upc_nxt = upc_inc;
      JT_SPIN:   upc_nxt = mem_busy ? upc : upc_inc;
      JT_FETCH:  upc_nxt = tgt;
      JT_DISP:   upc_nxt = grp_start;
      JT_FTRUE:  upc_nxt = br_cmp ? tgt : upc_inc;
      JT_FFALSE: upc_nxt = br_cmp ? upc_inc : tgt;
      default:   upc_nxt = upc_inc;
    endcase
  end
endmodule

// File: rtl/useq_core.sv
module useq_core
  import useq_pkg::*;
#(
  parameter int OPC_W = 7,
  parameter int UPC_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OPC_W-1:0]  opcode,
  input  logic              mem_busy,
  input  logic              br_cmp,
  output logic [CTRL_W-1:0] ctrl,
  output logic [UPC_W-1:0]  upc
);
  logic [UPC_W-1:0] upc_q;
  logic [UPC_W-1:0] upc_nxt;
  logic [UPC_W-1:0] grp_start;
  logic [UPC_W-1:0] word_tgt;
  ctrl_t            word_ctrl;
  jump_e            word_jt;

  useq_store #(.UPC_W(UPC_W)) u_store (
    .upc(upc_q), .word_ctrl(word_ctrl), .word_jt(word_jt), .word_tgt(word_tgt)
  );

  useq_dispatch #(.OPC_W(OPC_W), .UPC_W(UPC_W)) u_disp (
    .opcode(opcode), .grp_start(grp_start)
  );

  useq_next #(.UPC_W(UPC_W)) u_next (
    .upc(upc_q), .jt(word_jt), .tgt(word_tgt), .grp_start(grp_start),
    .mem_busy(mem_busy), .br_cmp(br_cmp), .upc_nxt(upc_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) upc_q <= UPC_W'(UA_FETCH);
    else     upc_q <= upc_nxt;
  end

  assign ctrl = word_ctrl;
  assign upc  = upc_q;
endmodule

// File: rtl/useq_core_chk.sv
module useq_core_chk #(
  parameter int OPC_W = 7,
  parameter int UPC_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic [OPC_W-1:0] opcode,
  input logic             mem_busy,
  input logic             br_cmp,
  input logic [2:0]       jt,
  input logic [UPC_W-1:0] tgt,
  input logic [UPC_W-1:0] upc
);
  localparam logic [UPC_W-1:0] TRAP = {UPC_W{1'b1}};

  // R1
  reset_to_fetch_chk: assert property (@(posedge clk) rst |=> upc == '0);
  // R2
  next_inc_chk: assert property (@(posedge clk) disable iff (rst)
    jt == 3'd0 |=> upc == $past(upc) + UPC_W'(1));
  // R3
  spin_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (jt == 3'd1 && mem_busy) |=> $stable(upc));
  // R3
  spin_go_chk: assert property (@(posedge clk) disable iff (rst)
    (jt == 3'd1 && !mem_busy) |=> upc == $past(upc) + UPC_W'(1));
  // R4
  fetch_abs_chk: assert property (@(posedge clk) disable iff (rst)
    jt == 3'd2 |=> upc == $past(tgt));
  // R5
  disp_alu_chk: assert property (@(posedge clk) disable iff (rst)
    (jt == 3'd3 && opcode == OPC_W'('h33)) |=> upc == UPC_W'(4));
  // R6
  ftrue_chk: assert property (@(posedge clk) disable iff (rst)
    (jt == 3'd4 && br_cmp) |=> upc == $past(tgt));
  // R6
  ffalse_chk: assert property (@(posedge clk) disable iff (rst)
    (jt == 3'd5 && !br_cmp) |=> upc == $past(tgt));
  // R10
  trap_stuck_chk: assert property (@(posedge clk) disable iff (rst)
    upc == TRAP |=> upc == TRAP);
endmodule

bind useq_core useq_core_chk #(.OPC_W(OPC_W), .UPC_W(UPC_W)) u_chk (
  .clk(clk), .rst(rst), .opcode(opcode), .mem_busy(mem_busy), .br_cmp(br_cmp),
  .jt(word_jt), .tgt(word_tgt), .upc(upc_q)
);

// File: tb/tb_useq_core.sv
module tb_useq_core;
  localparam int CLK_PERIOD = 10;
  localparam int OPC_W = 7;
  localparam int UPC_W = 6;
  localparam int NPROG = 12;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [OPC_W-1:0] opcode = '0;
  logic             mem_busy = 1'b0;
  logic             br_cmp = 1'b0;
  logic [16:0]      ctrl;
  logic [UPC_W-1:0] upc;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  useq_core #(.OPC_W(OPC_W), .UPC_W(UPC_W)) dut (
    .clk(clk), .rst(rst), .opcode(opcode), .mem_busy(mem_busy),
    .br_cmp(br_cmp), .ctrl(ctrl), .upc(upc)
  );

  // program: opcode, fetch wait, memory wait, compare value
  function automatic int prog_op(int i);
    case (i)
      0: return 'h33;  1: return 'h13;  2: return 'h03;  3: return 'h23;
      4: return 'h63;  5: return 'h63;  6: return 'h67;  7: return 'h67;
      8: return 'h6F;  9: return 'h03; 10: return 'h33;  default: return 'h7F;
    endcase
  endfunction
  function automatic int prog_fw(int i); return (i * 7) % 4; endfunction
  function automatic int prog_mw(int i); return (i == 9) ? 0 : 3; endfunction
  function automatic bit prog_cmp(int i); return (i == 4 || i == 7); endfunction

  function automatic int grp_of(int op);
    case (op)
      'h33: return 4;  'h13: return 7;  'h03: return 10; 'h23: return 15;
      'h63: return 20; 'h6F: return 26; 'h67: return 29; default: return 63;
    endcase
  endfunction

  // behavioural next-step model from the requirements
  function automatic int model_next(int s, int op, bit busy, bit cmp);
    case (s)
      1, 13, 18:               return busy ? s : s + 1;          // R3
      3:                       return grp_of(op);                // R5
      6, 9, 14, 19, 25, 28:    return 0;                         // R4
      22:                      return cmp ? 23 : 0;              // R9 / R6
      31:                      return cmp ? 0 : 32;              // R9 / R6
      32:                      return 23;
      63:                      return 63;                        // R10
      default:                 return s + 1;                     // R2
    endcase
  endfunction

  function automatic int strobe_of(int s);
    case (s)
      0: return 'h06; 1: return 'hA0; 2: return 'h12; 3: return 'h01;  // R7
      13: return 'h81; 18: return 'hC2; 14, 19, 32, 63: return 'h00;    // R8
      22: return 'h12; 25: return 'h01;                                  // R9
      default: return -1;
    endcase
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  initial begin : wdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    int exp_s;
    int idx;
    int busy_cnt;
    int in_trap;
    int cyc;
    bit cur_cmp;
    int cur_mw;
    exp_s = 0; idx = 0; busy_cnt = 0; in_trap = 0; cyc = 0; cur_cmp = 0; cur_mw = 0;
    repeat (3) @(negedge clk);
    check(upc == 0, "R1", int'(upc), 0);
    check(int'(ctrl[16:9]) == 'h06, "R1", int'(ctrl[16:9]), 'h06);
    rst = 1'b0;
    while (in_trap < 8 && cyc < 5000) begin
      if (exp_s == 0 && idx < NPROG) begin
        opcode   = OPC_W'(prog_op(idx));
        busy_cnt = prog_fw(idx);
        cur_mw   = prog_mw(idx);
        cur_cmp  = prog_cmp(idx);
        idx++;
      end
      if (exp_s == 12 || exp_s == 17) busy_cnt = cur_mw;
      if (exp_s == 1 || exp_s == 13 || exp_s == 18) begin
        mem_busy = (busy_cnt > 0);
        if (busy_cnt > 0) busy_cnt--;
      end else mem_busy = 1'b0;
      br_cmp = cur_cmp;
      exp_s = model_next(exp_s, int'(opcode), mem_busy, br_cmp);
      @(negedge clk);
      cyc++;
      check(int'(upc) == exp_s, "R2/R3/R4/R5/R6/R9 step", int'(upc), exp_s);
      if (strobe_of(exp_s) >= 0)
        check(int'(ctrl[16:9]) == strobe_of(exp_s), "R7/R8/R11 strobes",
              int'(ctrl[16:9]), strobe_of(exp_s));
      if (exp_s == 63) in_trap++;
    end
    check(idx == NPROG, "R10 program reached trap", idx, NPROG);
    check(upc == 6'd63, "R10 trap hold", int'(upc), 63);
    // R1: reset leaves trap
    rst = 1'b1;
    @(negedge clk);
    check(upc == 0, "R1 reset from trap", int'(upc), 0);
    rst = 1'b0;
    opcode = OPC_W'('h13);
    @(negedge clk);
    check(upc == 1, "R2 after reset", int'(upc), 1);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end
endmodule